// File: doc/BRIEF.md
# Interrupt Delay Coalescing Unit

This block sits between the receive and transmit DMA engines and the CPU interrupt line. It merges per-packet completion pulses into fewer, delayed interrupts. For each direction it counts completion events. It raises that direction's delayed cause when enough events have piled up, or when a programmed number of microseconds has passed with at least one event outstanding. A prescaler divides the system clock into a microsecond tick for these timeouts.

Software reaches four 32-bit words through a simple register port: a cause status word (write 1 to clear), an enable mask, the delay configuration and a global word that holds the cycles-per-microsecond divisor. The single interrupt output is a level signal. It is high whenever an enabled cause is pending. Raw per-packet causes are kept in the status word next to the two delayed causes.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the status word is 0, the enable word is 0, the delay configuration reads 0x8404_8404 (both directions enabled, threshold 4, timeout 4), the global word reads 0x0000_C800 (divisor 200) and irq is low.
- R2: Word index 0 is the status word. A receive done pulse sets bit 2, and a transmit done pulse on queue q (0..3) sets bit 8+q, in the cycle after the pulse.
- R3: Writing word 0 clears every status bit written as 1 and leaves bits written as 0 unchanged. A cause that is set in the same cycle as its clear stays set.
- R4: The delay configuration (word index 2) holds the receive setting in bits 15:0 and the transmit setting in bits 31:16. Each setting has an enable at bit 15, a threshold at bits 14:8 and a timeout at bits 7:0. With the enable set, the delayed cause (status bit 0 for receive, bit 1 for transmit) sets when the pending count plus this cycle's events reaches the threshold. The transmit count adds the number of queues pulsing in that cycle.
- R5: With the enable set and at least one event pending, the delayed cause sets on the microsecond tick at which the number of ticks seen while pending reaches the timeout.
- R6: Bits 15:8 of the global word (index 3) give N, the number of clock cycles per microsecond tick. A value of 0 acts as 1.
- R7: With a direction's enable clear, every done event of that direction sets its delayed cause in the next cycle.
- R8: Setting a delayed cause clears that direction's pending count and timer. Events that arrive while the cause is already set are counted toward the next delayed cause.
- R9: irq is high exactly when some bit is set in both the status word and the enable word (index 1).
- R10: Only bits 0, 1, 2 and 8..11 of the status and enable words exist. The delay configuration reads back all 32 bits. The global word reads back only bits 15:8.
- R11: A threshold of 0 disables the count trigger, and a timeout of 0 disables the timer trigger, for that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | One-cycle receive completion pulse |
| tx_done | input | 4 | One-cycle transmit completion pulse per queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 status, 1 enable, 2 delay config, 3 global |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt output |

## Verification
Two activities can land in the same cycle. One is a software write-1-to-clear of the status word. The other is a hardware set of the same cause, either a raw done pulse or a delayed cause that fires from the count or the timer. The bench provokes this collision on purpose: it writes all ones to the status word in the cycle where a pulse arrives, and in the cycle where the threshold event lands. Random traffic then mixes clears with events and ticks. A cycle-level model built from the requirements judges each case, with the rule that a set wins, and compares the status word and irq after every clock.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int          DIV_W     = 8,
  parameter int          QUEUES    = 4,
  parameter int          CNT_W     = 7,
  parameter int          TMO_W     = 8,
  parameter logic [7:0]  DIV_RESET = 8'd200,
  parameter logic [31:0] CFG_RESET = 32'h8404_8404
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [QUEUES-1:0] tx_done,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam logic [31:0] MASK     = 32'h0000_0007 | (((32'd1 << QUEUES) - 32'd1) << 8);
  localparam int          EV_W     = $clog2(QUEUES + 1);
  localparam int          SUM_W    = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TMO_W-1:0] TMR_MAX = '1;

  logic [31:0]      stat_q, en_q, cfg_q;
  logic [DIV_W-1:0] div_q, pre_q, div_eff;
  logic             tick;
  logic [1:0]       fire;
  logic [CNT_W-1:0] cnt_q [2];
  logic [TMO_W-1:0] tmr_q [2];
  logic [31:0]      set_v, clr_v;

  assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;
  assign tick    = pre_q >= div_eff - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + DIV_W'(1);

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [15:0]      c;
    logic [EV_W-1:0]  ev;
    logic [SUM_W-1:0] sum;
    logic             en, f_cnt, f_tmo;
    logic [CNT_W-1:0] thr;
    logic [TMO_W-1:0] tmo;

    assign c   = cfg_q[16*g +: 16];
    assign en  = c[15];
    assign thr = c[8 +: CNT_W];
    assign tmo = c[0 +: TMO_W];
    if (g == 0) begin : g_rx
      assign ev = EV_W'(rx_done);
    end else begin : g_tx
      assign ev = EV_W'($countones(tx_done));
    end
    assign sum   = SUM_W'(cnt_q[g]) + SUM_W'(ev);
    assign f_cnt = (thr != '0) && (sum >= SUM_W'(thr));
    assign f_tmo = (tmo != '0) && (cnt_q[g] != '0) && tick &&
                   ({1'b0, tmr_q[g]} + 9'd1 >= {1'b0, tmo});
    assign fire[g] = en ? (f_cnt || f_tmo) : (ev != '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[g] <= '0;
        tmr_q[g] <= '0;
      end else if (!en || fire[g]) begin
        cnt_q[g] <= '0;
        tmr_q[g] <= '0;
      end else begin
        cnt_q[g] <= (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
        if (cnt_q[g] == '0)
          tmr_q[g] <= '0;
        else if (tick && tmr_q[g] != TMR_MAX)
          tmr_q[g] <= tmr_q[g] + TMO_W'(1);
      end

    AST_CNT_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && thr != '0 && $stable(c)) |-> (cnt_q[g] < thr)); // R4
    AST_IDLE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == '0) |-> (tmr_q[g] == '0)); // R8
  end

  assign set_v = 32'({tx_done, 5'b0, rx_done, fire[1], fire[0]});
  assign clr_v = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      cfg_q  <= CFG_RESET;
      div_q  <= DIV_RESET;
    end else begin
      stat_q <= ((stat_q & ~clr_v) | set_v) & MASK;
      if (reg_wr) begin
        case (reg_addr)
          2'd1:    en_q  <= reg_wdata & MASK;
          2'd2:    cfg_q <= reg_wdata;
          2'd3:    div_q <= reg_wdata[8 +: DIV_W];
          default: ;
        endcase
      end
    end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = stat_q;
      2'd1:    reg_rdata = en_q;
      2'd2:    reg_rdata = cfg_q;
      default: reg_rdata = 32'(div_q) << 8;
    endcase

  assign irq = |(stat_q & en_q);

  AST_RX_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> stat_q[2]); // R2
  AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[2] && !rx_done) |=> !stat_q[2]); // R3
  AST_DIS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[15] && rx_done) |=> stat_q[0]); // R7
endmodule

// File: tb/test_irq_coalescer.sv
module test_irq_coalescer;
  logic        clk = 1'b0, rst_n = 1'b0, rx_done = 1'b0, reg_wr = 1'b0, irq;
  logic [3:0]  tx_done = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_stat, m_en, m_cfg;
  logic [7:0]  m_div, m_pre;
  int          m_cnt [2], m_tmr [2];

  always #2.5 clk = ~clk;

  irq_coalescer i_irq_coalescer (.clk, .rst_n, .rx_done, .tx_done, .reg_wr,
    .reg_addr, .reg_wdata, .reg_rdata, .irq);

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_en;
      2'd2: return m_cfg;
      default: return {16'b0, m_div, 8'b0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_step(input logic rx, input logic [3:0] tx, input logic wr,
                        input logic [1:0] a, input logic [31:0] d);
    int dv, ev, thr, tmo, sum;
    bit tick, en;
    logic [1:0] fr;
    logic [31:0] clr, st;
    dv   = (m_div == 0) ? 1 : m_div;
    tick = m_pre >= dv - 1;
    for (int g = 0; g < 2; g++) begin
      en  = m_cfg[16*g + 15];
      thr = (m_cfg >> (16*g + 8)) & 32'h7f;
      tmo = (m_cfg >> (16*g)) & 32'hff;
      ev  = (g == 0) ? int'(rx) : $countones(tx);
      sum = m_cnt[g] + ev;
      if (!en) fr[g] = ev != 0;
      else fr[g] = (thr != 0 && sum >= thr) ||
                   (tmo != 0 && m_cnt[g] != 0 && tick && m_tmr[g] + 1 >= tmo);
      if (!en || fr[g]) begin m_cnt[g] = 0; m_tmr[g] = 0; end
      else begin
        if (m_cnt[g] == 0) m_tmr[g] = 0;
        else if (tick && m_tmr[g] < 255) m_tmr[g]++;
        m_cnt[g] = (sum > 127) ? 127 : sum;
      end
    end
    m_pre = tick ? 8'd0 : m_pre + 8'd1;
    clr = (wr && a == 2'd0) ? d : 32'd0;
    st  = {20'b0, tx, 5'b0, rx, fr};
    m_stat = ((m_stat & ~clr) | st) & 32'h0f07;
    if (wr) case (a)
      2'd1: m_en = d & 32'h0f07;
      2'd2: m_cfg = d;
      2'd3: m_div = d[15:8];
      default: ;
    endcase
  endtask

  task automatic cyc(input string tag, input logic rx, input logic [3:0] tx,
                     input logic wr = 0, input logic [1:0] a = 0, input logic [31:0] d = 0);
    @(negedge clk);
    rx_done = rx; tx_done = tx; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_step(rx, tx, wr, a, d);
    #1;
    check({tag, " irq (R9)"}, 32'(irq), 32'(|(m_stat & m_en)));
    if (!wr) check(tag, reg_rdata, m_read(a));
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc("write", 0, 0, 1, a, d);
  endtask

  task automatic rd_exp(input string tag, input logic [1:0] a, input logic [31:0] exp);
    cyc(tag, 0, 0, 0, a);
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_stat = 0; m_en = 0; m_cfg = 32'h8404_8404; m_div = 8'd200; m_pre = 0;
    m_cnt = '{0, 0}; m_tmr = '{0, 0};
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq after reset", 32'(irq), 0);
    rst_n = 1'b1;
    rd_exp("R1 status", 0, 32'h0);
    rd_exp("R1 enable", 1, 32'h0);
    rd_exp("R1 config", 2, 32'h8404_8404);
    rd_exp("R1 global", 3, 32'h0000_C800);

    wr(1, 32'hFFFF_FFFF);
    rd_exp("R10 enable mask", 1, 32'h0000_0F07);
    wr(3, 32'hFFFF_03FF);
    rd_exp("R10 global mask", 3, 32'h0000_0300);
    wr(0, 32'hFFFF_FFFF);

    // R4: threshold 4 on RX, timeouts off
    wr(2, 32'h8400_8400);
    for (int i = 0; i < 3; i++) cyc("R4 rx below thr", 1, 0);
    check("R4 no delayed rx yet", 32'(reg_rdata[0]), 0);
    cyc("R4 rx reaches thr", 1, 0);
    check("R4 delayed rx set", 32'(reg_rdata[0]), 1);
    // R8: events while set still count
    for (int i = 0; i < 3; i++) cyc("R8 rx while set", 1, 0);
    wr(0, 32'h1);
    check("R8 after clear", 32'(m_stat[0]), 0);
    cyc("R8 next threshold", 1, 0);
    check("R8 fired on 4th counted", 32'(reg_rdata[0]), 1);
    // R4 tx popcount, R3 collision with threshold
    wr(0, 32'hFFFF_FFFF);
    cyc("R4 tx 3 queues", 0, 4'b0111);
    cyc("R3 collide clear with fire", 0, 4'b1000, 1, 0, 32'hFFFF_FFFF);
    rd_exp("R3 set wins", 0, 32'h0000_0802);
    // R2 raw bits
    wr(0, 32'hFFFF_FFFF);
    cyc("R2 rx raw", 1, 0);
    check("R2 bit2", 32'(reg_rdata[2]), 1);
    cyc("R3 collide clear with raw", 1, 0, 1, 0, 32'h4);
    rd_exp("R3 raw survives", 0, m_stat);
    check("R3 raw bit kept", 32'(m_stat[2]), 1);
    wr(0, 32'h0);
    rd_exp("R3 zero write no effect", 0, m_stat);

    // R5/R6: timeout 4 with divisor 2
    wr(0, 32'hFFFF_FFFF);
    wr(3, 32'h0000_0200);
    wr(2, 32'h8004_8004);
    cyc("R5 single rx", 1, 0);
    wr(0, 32'h4);
    idle("R5 wait", 12);
    check("R5 timeout fired", 32'(reg_rdata[0]), 1);
    wr(0, 32'hFFFF_FFFF);
    idle("R5 no pending no fire", 20);
    check("R5 quiet", 32'(reg_rdata[1:0]), 0);
    wr(3, 32'h0);
    cyc("R6 div0 rx", 1, 0);
    idle("R6 div0 wait", 6);

    // R7 disabled direction
    wr(2, 32'h0000_0000);
    wr(0, 32'hFFFF_FFFF);
    cyc("R7 rx immediate", 1, 0);
    check("R7 bit0", 32'(reg_rdata[0]), 1);
    cyc("R7 tx immediate", 0, 4'b0001);
    check("R7 bit1", 32'(reg_rdata[1]), 1);

    // R11 threshold 0 and timeout 0
    wr(3, 32'h0000_0100);
    wr(0, 32'hFFFF_FFFF);
    wr(2, 32'h8000_8000);
    for (int i = 0; i < 20; i++) cyc("R11 both off", 1, 4'hF);
    check("R11 no delayed", 32'(reg_rdata[1:0]), 0);

    // R9 irq per mask
    wr(1, 32'h0000_0004);
    wr(0, 32'hFFFF_FFFF);
    cyc("R9 masked tx", 0, 4'h1);
    check("R9 irq low", 32'(irq), 0);
    cyc("R9 enabled rx", 1, 0);
    check("R9 irq high", 32'(irq), 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3)
        cyc("R4 rand cfg", 0, 0, 1, 2, {($urandom_range(0, 3) != 0), 7'($urandom_range(0, 6)),
            8'($urandom_range(0, 5)), ($urandom_range(0, 3) != 0), 7'($urandom_range(0, 6)),
            8'($urandom_range(0, 5))});
      else if (r < 5) cyc("R6 rand div", 0, 0, 1, 3, 32'($urandom_range(0, 4)) << 8);
      else if (r < 7) cyc("R9 rand en", 0, 0, 1, 1, $urandom);
      else if (r < 20) cyc("R3 rand clr", 1'($urandom), 4'($urandom), 1, 0, $urandom);
      else cyc("R8 rand traffic", ($urandom_range(0, 3) == 0), 4'($urandom & $urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule